// File: doc/BRIEF.md
# Toggle-Kicked Watchdog Timer

This block guards a processor against a hung program. The software proves that it is alive by flipping a kick line. A rising flip and a falling flip count the same. The block samples that line through a synchroniser and looks for a change of level in either direction. It also counts pulses of a slow timebase strobe. If the counter reaches the configured limit with no change of level on the kick line, the block sends a single-cycle expiry request to the reset sequencer. The sequencer then produces the actual system reset pulse.

The block also watches the current system reset status. While the system is held in reset, the counter is forced to zero and does not advance. After an expiry the block stays silent. It waits for the sequencer to assert and then release reset, and only then starts counting again from zero. The timeout is set at build time as a number of strobes. With a 1 ms strobe, the default of 1600 gives the nominal 1.6 s window, inside an allowed range of 1.0 s to 2.1 s.

Top module: `wdt_toggle_top`

## Requirements
- R1: After the block reset `rst`, `expire` is 0, and the first expiry needs a full `TIMEOUT` strobes with no kick activity.
- R2: A low-to-high change on `kick_async` clears the count, so a full `TIMEOUT` further strobes are needed before expiry.
- R3: A high-to-low change on `kick_async` clears the count in the same way as a rising change.
- R4: When `TIMEOUT` strobes have arrived since the last clear with no kick change, `expire` is 1 for exactly one clock cycle, in the cycle after the clock edge that samples the final strobe.
- R5: Only clock cycles with `tick` = 1 advance the count. Cycles without a strobe do not move the count toward expiry.
- R6: While `sys_rst_active` = 1, the count is held at zero and `expire` stays 0, whatever the strobes do. After release, expiry again needs `TIMEOUT` strobes.
- R7: After an expiry, no further expiry occurs until `sys_rst_active` has been asserted and then released. Counting then resumes from zero.
- R8: A kick change that reaches the counter in the same cycle as the strobe that would have ended the window clears the count, and no expiry occurs.
- R9: `kick_async` passes through a two-flop synchroniser and then an edge register. A change applied before clock edge k clears the counter at clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Timebase strobe, one cycle wide per period |
| kick_async | input | 1 | Asynchronous kick line from the processor |
| sys_rst_active | input | 1 | High while the system reset is asserted |
| expire | output | 1 | Single-cycle expiry request to the reset sequencer |

## Verification
The bench goes after four corner cases:
- A kick whose synchronised change lands on the terminal strobe. A design that gives the strobe priority would fire a spurious expiry.
- Long stretches of strobes after an expiry with no reset handshake. A design that re-arms by itself would repeat the request every window.
- Falling kicks tested apart from rising ones. A design with a single-polarity detector would time out while software is still kicking.
- Strobes spread between idle cycles, and strobes during system reset. A design that counts clock cycles or keeps its count through reset would expire early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [0:0] {
        WD_RUN  = 1'b0,
        WD_WAIT = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic       clear;
        logic       advance;
    } wd_cmd_t;

    function automatic wd_cmd_t wd_decode(input logic held, input logic edge_seen,
                                          input logic strobe);
        wd_cmd_t c;
        c.clear   = held | edge_seen;
        c.advance = strobe & ~c.clear;
        return c;
    endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_edge_det.sv
module wdt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic any_edge
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign any_edge = level ^ prev_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int TIMEOUT = 1600
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tick,
    input  logic                              kick_edge,
    input  logic                              sys_rst_active,
    output logic [$clog2(TIMEOUT+1)-1:0]      cnt_o,
    output logic                              expire_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    wd_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic expire_q;
    wd_cmd_t cmd;

    always_comb cmd = wd_decode(state_q == WD_WAIT, kick_edge, tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WD_RUN;
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (sys_rst_active) begin
                state_q <= WD_RUN;
                cnt_q   <= '0;
            end else if (cmd.clear) begin
                cnt_q <= '0;
            end else if (cmd.advance) begin
                if (cnt_q == LAST) begin
                    expire_q <= 1'b1;
                    cnt_q    <= '0;
                    state_q  <= WD_WAIT;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = expire_q;
endmodule

// File: rtl/wdt_toggle_top.sv
module wdt_toggle_top #(
    parameter int TIMEOUT     = 1600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic kick_async,
    input  logic sys_rst_active,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic          kick_s;
    logic          kick_edge;
    logic [CW-1:0] cnt_w;

    wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(kick_async), .q_sync(kick_s)
    );

    wdt_edge_det u_edge (
        .clk(clk), .rst(rst), .level(kick_s), .any_edge(kick_edge)
    );

    wdt_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .kick_edge(kick_edge),
        .sys_rst_active(sys_rst_active), .cnt_o(cnt_w), .expire_o(expire)
    );
endmodule

// File: rtl/wdt_toggle_chk.sv
module wdt_toggle_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          sys_rst_active,
    input logic          expire,
    input logic [CW-1:0] cnt
);
    logic fired_q;

    always_ff @(posedge clk) begin
        if (rst)                 fired_q <= 1'b0;
        else if (sys_rst_active) fired_q <= 1'b0;
        else if (expire)         fired_q <= 1'b1;
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire); // R4

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        sys_rst_active |=> !expire); // R6

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (rst)
        sys_rst_active |=> (cnt == '0)); // R6

    AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(expire) |-> $past(tick)); // R5

    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
        !(expire && fired_q)); // R7

    always_comb begin
        if (!rst) begin
            AST_RESET_LOW: assert (!(expire && $isunknown(cnt))); // R1
        end
    end
endmodule

bind wdt_toggle_top wdt_toggle_chk #(.CW($clog2(TIMEOUT + 1))) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .sys_rst_active(sys_rst_active),
    .expire(expire), .cnt(cnt_w)
);

// File: tb/wdt_toggle_top_bench.sv
module wdt_toggle_top_bench;
    localparam int T = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic kick = 1'b0;
    logic sr = 1'b0;
    logic expire;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wdt_toggle_top #(.TIMEOUT(T)) u_wdt_toggle_top (
        .clk(clk), .rst(rst), .tick(tick), .kick_async(kick),
        .sys_rst_active(sr), .expire(expire)
    );

    // Requirement-level reference: two sync stages plus an edge register (R9)
    logic m1, m2, m3, m_exp, m_wait;
    int   m_cnt;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m1 <= 0; m2 <= 0; m3 <= 0; m_exp <= 0; m_wait <= 0; m_cnt <= 0;
        end else begin
            m1 <= kick; m2 <= m1; m3 <= m2; m_exp <= 0;
            if (sr) begin m_cnt <= 0; m_wait <= 0; end
            else if (m_wait || (m2 != m3)) m_cnt <= 0;
            else if (tick) begin
                if (m_cnt == T-1) begin m_exp <= 1; m_cnt <= 0; m_wait <= 1; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(posedge clk) if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: bench hung, actual=%0d expected=<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare against reference at next negedge
    task automatic step(input logic t, input logic s, input string tag);
        tick = t; sr = s;
        @(negedge clk);
        check(expire, m_exp, tag);
    endtask

    function automatic int ticks_needed();
        return T;
    endfunction

    // strobe until expiry; returns strobes used (0 if none within limit)
    task automatic count_to_expire(input int gap, input int limit, input string tag,
                                   output int used);
        used = 0;
        for (int i = 1; i <= limit; i++) begin
            for (int g = 0; g < gap; g++) step(0, 0, tag);
            step(1, 0, tag);
            if (expire) begin used = i; return; end
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sys_reset_pulse();
        step(0, 1, "R7 handshake");
        step(0, 1, "R7 handshake");
        step(0, 0, "R7 handshake");
    endtask

    initial begin
        int used;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(expire, 1'b0, "R1 reset state");

        count_to_expire(0, 3*T, "R1 first window", used);
        chk_int(used, ticks_needed(), "R1 first window length");
        step(0, 0, "R4 pulse width");
        check(expire, 1'b0, "R4 single cycle");
        sys_reset_pulse();

        // R2 rising kick mid-window
        for (int i = 0; i < T-4; i++) step(1, 0, "R2");
        kick = 1;
        step(0, 0, "R2"); step(0, 0, "R2"); step(0, 0, "R2");
        count_to_expire(0, 3*T, "R2", used);
        chk_int(used, T, "R2 rising kick clears");
        sys_reset_pulse();

        // R3 falling kick mid-window
        for (int i = 0; i < T-2; i++) step(1, 0, "R3");
        kick = 0;
        step(0, 0, "R3"); step(0, 0, "R3"); step(0, 0, "R3");
        count_to_expire(0, 3*T, "R3", used);
        chk_int(used, T, "R3 falling kick clears");
        sys_reset_pulse();

        // R5 sparse strobes
        count_to_expire(3, 3*T, "R5", used);
        chk_int(used, T, "R5 only strobes count");
        sys_reset_pulse();

        // R6 held in system reset
        for (int i = 0; i < 3*T; i++) begin
            step(1, 1, "R6 held");
            check(expire, 1'b0, "R6 no expiry in reset");
        end
        step(0, 0, "R6");
        count_to_expire(0, 3*T, "R6 after release", used);
        chk_int(used, T, "R6 restart from zero");

        // R7 no re-fire without handshake
        count_to_expire(0, 3*T, "R7 silent", used);
        chk_int(used, 0, "R7 no refire");
        sys_reset_pulse();
        count_to_expire(0, 3*T, "R7 rearmed", used);
        chk_int(used, T, "R7 rearmed window");
        sys_reset_pulse();

        // R8 / R9: kick changed at step j clears at step j+2, same as terminal strobe
        for (int i = 0; i < T-1; i++) step(1, 0, "R8");
        kick = ~kick;
        step(0, 0, "R9 latency");
        step(0, 0, "R9 latency");
        step(1, 0, "R8 terminal");
        check(expire, 1'b0, "R8 kick beats terminal strobe");
        count_to_expire(0, 3*T, "R8", used);
        chk_int(used, T, "R8 full window after clear");
        sys_reset_pulse();

        // random mix against reference
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) kick = ~kick;
            step(logic'($urandom_range(0, 2) == 0),
                 logic'($urandom_range(0, 60) == 0), "R4 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule